// File: doc/BRIEF.md
# Two-Sided Inter-Processor Message Unit

This block connects two processors, called side A and side B, that share one clock. Each side has a 32-bit register port with four transmit word slots, four receive word slots, a status word and a control word. A word that one side writes into transmit slot n appears in receive slot n of the other side. Empty and full flags for each slot show both processors where every word is in the handshake. Separately from the data path, each side can ring four doorbells toward the other side. Each side has one interrupt line, and the control word decides which status flags drive it.

Each word slot in each direction is a two-state machine: SLOT_EMPTY and SLOT_FULL. A write to the transmit slot takes it from SLOT_EMPTY to SLOT_FULL. A further write while full stays in SLOT_FULL and replaces the word. A read of the receive slot takes SLOT_FULL back to SLOT_EMPTY. If a read and a write land in the same cycle, the write wins. Each doorbell in each direction is a three-state machine: DB_IDLE, DB_RING and DB_PEND. A request moves DB_IDLE to DB_RING. DB_RING always moves to DB_PEND on the next cycle. A clear moves DB_PEND to DB_IDLE. If a clear and a new request arrive in the same cycle, DB_PEND moves to DB_RING. A request that arrives in DB_RING or DB_PEND is merged into the doorbell already in flight.

Top module: `msg_unit_top`

## Requirements
- R1: After reset, each side's status word reads 0x00F00000 (all transmit slots empty, nothing received, no doorbell pending), each control word reads 0, and both interrupt lines are low.
- R2: A write to transmit offset 0x00, 0x04, 0x08 or 0x0C (slot 0 to 3) takes effect on the next clock edge. From then on, the writer's transmit-empty bit 20+(3-n) is clear, the other side's receive-full bit 24+(3-n) is set, and the other side reads the word at receive offset 0x10+4n.
- R3: A read of receive slot n clears the reader's receive-full bit 24+(3-n) and sets the sender's transmit-empty bit 20+(3-n) from the next edge.
- R4: The slots are independent. Both sides may write, or both sides may read, different slots in the same cycle without any effect on each other.
- R5: Writing 1 to control bit 16+(3-n) requests doorbell n. That bit reads back as 1 for exactly one cycle and then clears by itself. At the same moment, the other side's status bit 28+(3-n) becomes set.
- R6: A doorbell-pending bit is cleared only by writing 1 to it in the status word. Writing 0 to it, or writing any other status bit, leaves it unchanged. A new request while the bit is already pending leaves it pending and raises no second request.
- R7: A side's interrupt line is high exactly when some status bit in 20..31 is set and the control bit at the same position is also set.
- R8: While a side's reset input is high, the other side's status bit 9 reads 1. A cycle with that input high clears the side's control word.
- R9: The status word is at offset 0x20 and the control word at 0x24. A read of a transmit offset returns 0.
- R10: A second write to a slot that is still full replaces the word, and one read empties the slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for both sides |
| rst_n | input | 1 | Active-low reset of the whole block |
| a_side_rst | input | 1 | Side A reset in progress; clears A's control word |
| a_wr_en | input | 1 | Side A register write strobe |
| a_rd_en | input | 1 | Side A register read strobe |
| a_addr | input | 6 | Side A byte offset |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A read data, combinational from a_addr |
| a_irq | output | 1 | Side A interrupt |
| b_side_rst | input | 1 | Side B reset in progress; clears B's control word |
| b_wr_en | input | 1 | Side B register write strobe |
| b_rd_en | input | 1 | Side B register read strobe |
| b_addr | input | 6 | Side B byte offset |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B read data, combinational from b_addr |
| b_irq | output | 1 | Side B interrupt |

## Verification
Every slot and doorbell state can be read in one of the two status words, so a state machine in the wrong state appears there one edge after the access that caused it. A slot stuck in SLOT_FULL shows a transmit-empty bit that stays clear after the read. A doorbell that skips DB_RING shows a request bit that never reads 1. A doorbell that leaves DB_PEND without a clear shows a pending bit that drops when nothing cleared it. An enable register that is corrupted appears on the interrupt line in the same cycle, because the line is a combinational function of status and enables.

// File: rtl/msg_unit_pkg.sv
package msg_unit_pkg;
    localparam int NSLOT    = 4;
    localparam int DW       = 32;
    localparam int AW       = 6;
    localparam int TE_LSB   = 20;
    localparam int RF_LSB   = 24;
    localparam int GP_LSB   = 28;
    localparam int RQ_LSB   = 16;
    localparam int PEER_BIT = 9;
    localparam int ENW      = 3 * NSLOT;

    typedef enum logic {SLOT_EMPTY, SLOT_FULL} slot_st_t;
    typedef enum logic [1:0] {DB_IDLE, DB_RING, DB_PEND} db_st_t;

    // slot n sits at the highest bit of its field, so fields are mirrored
    function automatic logic [NSLOT-1:0] mirror(input logic [NSLOT-1:0] v);
        logic [NSLOT-1:0] r;
        for (int i = 0; i < NSLOT; i++) r[NSLOT-1-i] = v[i];
        return r;
    endfunction
endpackage

// File: rtl/msg_slot.sv
module msg_slot
    import msg_unit_pkg::*;
#(
    parameter int W = DW
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic         rd,
    input  logic [W-1:0] wdata,
    output logic         full,
    output logic [W-1:0] data
);
    slot_st_t st, st_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= SLOT_EMPTY;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            SLOT_EMPTY: if (wr) st_nx = SLOT_FULL;
            SLOT_FULL:  if (!wr && rd) st_nx = SLOT_EMPTY;
            default:    st_nx = SLOT_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  data <= '0;
        else if (wr) data <= wdata;
    end

    always_comb full = (st == SLOT_FULL);
endmodule

// File: rtl/msg_doorbell.sv
module msg_doorbell
    import msg_unit_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ring,
    input  logic clear,
    output logic req,
    output logic pend
);
    db_st_t st, st_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= DB_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            DB_IDLE: if (ring) st_nx = DB_RING;
            DB_RING: st_nx = DB_PEND;
            DB_PEND: if (clear) st_nx = ring ? DB_RING : DB_IDLE;
            default: st_nx = DB_IDLE;
        endcase
    end

    always_comb begin
        req  = (st == DB_RING);
        pend = (st == DB_PEND);
    end
endmodule

// File: rtl/msg_side.sv
module msg_side
    import msg_unit_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      side_rst,
    input  logic                      wr_en,
    input  logic                      rd_en,
    input  logic [AW-1:0]             addr,
    input  logic [DW-1:0]             wdata,
    input  logic [NSLOT-1:0]          tx_full,
    input  logic [NSLOT-1:0]          rx_full,
    input  logic [NSLOT-1:0][DW-1:0]  rx_data,
    input  logic [NSLOT-1:0]          db_in_pend,
    input  logic [NSLOT-1:0]          db_out_req,
    input  logic                      peer_rst,
    output logic [DW-1:0]             rdata,
    output logic                      irq,
    output logic [NSLOT-1:0]          tx_wr,
    output logic [NSLOT-1:0]          rx_rd,
    output logic [NSLOT-1:0]          db_ring,
    output logic [NSLOT-1:0]          db_clear,
    output logic [ENW-1:0]            en
);
    localparam int WW    = AW - 2;
    localparam int W_ST  = 2 * NSLOT;
    localparam int W_CT  = 2 * NSLOT + 1;

    logic [WW-1:0]    word;
    logic [NSLOT-1:0] is_tx, is_rx;
    logic             is_st, is_ct;
    logic [DW-1:0]    stat, ctrl;

    always_comb begin
        word  = addr[AW-1:2];
        is_st = (word == WW'(W_ST));
        is_ct = (word == WW'(W_CT));
        for (int i = 0; i < NSLOT; i++) begin
            is_tx[i] = (word == WW'(i));
            is_rx[i] = (word == WW'(NSLOT + i));
        end
        tx_wr    = wr_en ? is_tx : '0;
        rx_rd    = rd_en ? is_rx : '0;
        db_ring  = (wr_en && is_ct) ? mirror(wdata[RQ_LSB +: NSLOT]) : '0;
        db_clear = (wr_en && is_st) ? mirror(wdata[GP_LSB +: NSLOT]) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               en <= '0;
        else if (side_rst)        en <= '0;
        else if (wr_en && is_ct)  en <= wdata[TE_LSB +: ENW];
    end

    always_comb begin
        stat = '0;
        stat[TE_LSB +: NSLOT] = mirror(~tx_full);
        stat[RF_LSB +: NSLOT] = mirror(rx_full);
        stat[GP_LSB +: NSLOT] = mirror(db_in_pend);
        stat[PEER_BIT]        = peer_rst;
        ctrl = '0;
        ctrl[TE_LSB +: ENW]   = en;
        ctrl[RQ_LSB +: NSLOT] = mirror(db_out_req);
        irq  = |(stat[TE_LSB +: ENW] & en);
    end

    always_comb begin
        rdata = '0;
        if (is_st) rdata = stat;
        if (is_ct) rdata = ctrl;
        for (int i = 0; i < NSLOT; i++)
            if (is_rx[i]) rdata = rx_data[i];
    end
endmodule

// File: rtl/msg_unit_top.sv
module msg_unit_top
    import msg_unit_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          a_side_rst,
    input  logic          a_wr_en,
    input  logic          a_rd_en,
    input  logic [AW-1:0] a_addr,
    input  logic [DW-1:0] a_wdata,
    output logic [DW-1:0] a_rdata,
    output logic          a_irq,
    input  logic          b_side_rst,
    input  logic          b_wr_en,
    input  logic          b_rd_en,
    input  logic [AW-1:0] b_addr,
    input  logic [DW-1:0] b_wdata,
    output logic [DW-1:0] b_rdata,
    output logic          b_irq
);
    logic [NSLOT-1:0]         a_tx_wr, a_rx_rd, a_db_ring, a_db_clear;
    logic [NSLOT-1:0]         b_tx_wr, b_rx_rd, b_db_ring, b_db_clear;
    logic [NSLOT-1:0]         a2b_full, b2a_full;
    logic [NSLOT-1:0][DW-1:0] a2b_data, b2a_data;
    logic [NSLOT-1:0]         a_req, b_req, a_pend, b_pend;
    logic [ENW-1:0]           a_en, b_en;

    for (genvar i = 0; i < NSLOT; i++) begin : g_lane
        msg_slot u_a2b (.clk(clk), .rst_n(rst_n), .wr(a_tx_wr[i]), .rd(b_rx_rd[i]),
                        .wdata(a_wdata), .full(a2b_full[i]), .data(a2b_data[i]));
        msg_slot u_b2a (.clk(clk), .rst_n(rst_n), .wr(b_tx_wr[i]), .rd(a_rx_rd[i]),
                        .wdata(b_wdata), .full(b2a_full[i]), .data(b2a_data[i]));
        msg_doorbell u_dab (.clk(clk), .rst_n(rst_n), .ring(a_db_ring[i]),
                            .clear(b_db_clear[i]), .req(a_req[i]), .pend(b_pend[i]));
        msg_doorbell u_dba (.clk(clk), .rst_n(rst_n), .ring(b_db_ring[i]),
                            .clear(a_db_clear[i]), .req(b_req[i]), .pend(a_pend[i]));
    end

    msg_side u_side_a (
        .clk(clk), .rst_n(rst_n), .side_rst(a_side_rst), .wr_en(a_wr_en), .rd_en(a_rd_en),
        .addr(a_addr), .wdata(a_wdata), .tx_full(a2b_full), .rx_full(b2a_full),
        .rx_data(b2a_data), .db_in_pend(a_pend), .db_out_req(a_req), .peer_rst(b_side_rst),
        .rdata(a_rdata), .irq(a_irq), .tx_wr(a_tx_wr), .rx_rd(a_rx_rd),
        .db_ring(a_db_ring), .db_clear(a_db_clear), .en(a_en));

    msg_side u_side_b (
        .clk(clk), .rst_n(rst_n), .side_rst(b_side_rst), .wr_en(b_wr_en), .rd_en(b_rd_en),
        .addr(b_addr), .wdata(b_wdata), .tx_full(b2a_full), .rx_full(a2b_full),
        .rx_data(a2b_data), .db_in_pend(b_pend), .db_out_req(b_req), .peer_rst(a_side_rst),
        .rdata(b_rdata), .irq(b_irq), .tx_wr(b_tx_wr), .rx_rd(b_rx_rd),
        .db_ring(b_db_ring), .db_clear(b_db_clear), .en(b_en));
endmodule

// File: rtl/msg_unit_chk.sv
module msg_unit_chk
    import msg_unit_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             a_side_rst,
    input logic             a_irq,
    input logic [NSLOT-1:0] a_tx_wr,
    input logic [NSLOT-1:0] b_rx_rd,
    input logic [NSLOT-1:0] a2b_full,
    input logic [NSLOT-1:0] a_req,
    input logic [NSLOT-1:0] b_pend,
    input logic [NSLOT-1:0] b_db_clear,
    input logic [ENW-1:0]   a_en
);
    assert_tx_fills_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (a_tx_wr != '0) |=> ((a2b_full & $past(a_tx_wr)) == $past(a_tx_wr)));

    assert_rx_drains_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((b_rx_rd & ~a_tx_wr) != '0) |=> ((a2b_full & $past(b_rx_rd & ~a_tx_wr)) == '0));

    assert_req_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (a_req != '0) |=> (((a_req & $past(a_req)) == '0) &&
                           ((b_pend & $past(a_req)) == $past(a_req))));

    assert_pend_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((b_pend & ~b_db_clear) != '0) |=> ((b_pend & $past(b_pend & ~b_db_clear)) == $past(b_pend & ~b_db_clear)));

    assert_irq_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (a_en == '0) |-> !a_irq);

    assert_side_rst_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        a_side_rst |=> (a_en == '0));
endmodule

bind msg_unit_top msg_unit_chk u_chk (
    .clk(clk), .rst_n(rst_n), .a_side_rst(a_side_rst), .a_irq(a_irq),
    .a_tx_wr(a_tx_wr), .b_rx_rd(b_rx_rd), .a2b_full(a2b_full), .a_req(a_req),
    .b_pend(b_pend), .b_db_clear(b_db_clear), .a_en(a_en));

// File: tb/sim_msg_unit_top.sv
`timescale 1ns/1ps
module sim_msg_unit_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        a_side_rst = 1'b0, b_side_rst = 1'b0;
    logic        a_wr_en = 1'b0, a_rd_en = 1'b0, b_wr_en = 1'b0, b_rd_en = 1'b0;
    logic [5:0]  a_addr = '0, b_addr = '0;
    logic [31:0] a_wdata = '0, b_wdata = '0;
    logic [31:0] a_rdata, b_rdata;
    logic        a_irq, b_irq;
    int          n_chk = 0, n_err = 0;
    bit          done = 1'b0;

    localparam logic [5:0] ST = 6'h20, CT = 6'h24;

    always #2.5 clk = ~clk;

    msg_unit_top u0 (.*);

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    // one register access on one side; starts and ends at a falling edge
    task automatic acc(input bit side_b, input bit wr, input bit rd,
                       input logic [5:0] ad, input logic [31:0] wd, output logic [31:0] rv);
        if (side_b) begin b_wr_en = wr; b_rd_en = rd; b_addr = ad; b_wdata = wd; end
        else        begin a_wr_en = wr; a_rd_en = rd; a_addr = ad; a_wdata = wd; end
        #1;
        rv = side_b ? b_rdata : a_rdata;
        @(negedge clk);
        a_wr_en = 0; a_rd_en = 0; b_wr_en = 0; b_rd_en = 0;
    endtask

    task automatic rd_chk(input bit side_b, input logic [5:0] ad, input string req,
                          input logic [31:0] exp);
        logic [31:0] v;
        acc(side_b, 0, 1, ad, '0, v);
        chk(req, v, exp);
    endtask

    task automatic wr(input bit side_b, input logic [5:0] ad, input logic [31:0] wd);
        logic [31:0] v;
        acc(side_b, 1, 0, ad, wd, v);
    endtask

    task automatic t_reset;
        rd_chk(0, ST, "R1 a status", 32'h00F00000);
        rd_chk(1, ST, "R1 b status", 32'h00F00000);
        rd_chk(0, CT, "R1 a control", 32'h0);
        rd_chk(1, CT, "R1 b control", 32'h0);
        chk("R1 irqs", {30'd0, a_irq, b_irq}, 32'h0);
    endtask

    task automatic t_map;
        wr(0, 6'h08, 32'h0000_2222);
        rd_chk(0, 6'h08, "R9 tx reads zero", 32'h0);
        rd_chk(1, ST, "R2 peer rf slot2", 32'h02F00000);
        rd_chk(0, ST, "R2 own te slot2", 32'h00D00000);
        rd_chk(1, 6'h18, "R2 R9 rx slot2 data", 32'h0000_2222);
        rd_chk(1, ST, "R3 rf cleared", 32'h00F00000);
        rd_chk(0, ST, "R3 te set", 32'h00F00000);
    endtask

    task automatic t_parallel;
        a_wr_en = 1; a_addr = 6'h00; a_wdata = 32'hA0A0_0000;
        b_wr_en = 1; b_addr = 6'h0C; b_wdata = 32'hB3B3_0003;
        @(negedge clk);
        a_wr_en = 0; b_wr_en = 0;
        rd_chk(0, ST, "R4 a status", 32'h01700000);
        rd_chk(1, ST, "R4 b status", 32'h08E00000);
        a_rd_en = 1; a_addr = 6'h1C; b_rd_en = 1; b_addr = 6'h10;
        #1;
        chk("R4 a reads slot3", a_rdata, 32'hB3B3_0003);
        chk("R4 b reads slot0", b_rdata, 32'hA0A0_0000);
        @(negedge clk);
        a_rd_en = 0; b_rd_en = 0;
        rd_chk(0, ST, "R4 a drained", 32'h00F00000);
        rd_chk(1, ST, "R4 b drained", 32'h00F00000);
    endtask

    task automatic t_overwrite;
        wr(0, 6'h04, 32'h11);
        wr(0, 6'h04, 32'h12);
        rd_chk(1, ST, "R10 still full", 32'h04F00000);
        rd_chk(1, 6'h14, "R10 newest word", 32'h12);
        rd_chk(1, ST, "R10 one read empties", 32'h00F00000);
    endtask

    task automatic t_doorbell;
        wr(0, CT, 32'h0008_0000);
        rd_chk(0, CT, "R5 request visible", 32'h0008_0000);
        rd_chk(0, CT, "R5 request self-clears", 32'h0);
        rd_chk(1, ST, "R5 peer pending", 32'h80F00000);
        wr(0, CT, 32'h0008_0000);
        rd_chk(0, CT, "R6 merged request", 32'h0);
        rd_chk(1, ST, "R6 still pending", 32'h80F00000);
        wr(1, ST, 32'h0FFF_FFFF);
        rd_chk(1, ST, "R6 other bits no effect", 32'h80F00000);
        wr(1, ST, 32'h8000_0000);
        rd_chk(1, ST, "R6 w1c", 32'h00F00000);
    endtask

    task automatic t_irq;
        wr(1, CT, 32'h0800_0000);
        chk("R7 no flag no irq", {31'd0, b_irq}, 32'h0);
        wr(0, 6'h00, 32'h5);
        #1 chk("R7 rf irq", {31'd0, b_irq}, 32'h1);
        rd_chk(1, 6'h10, "R7 data", 32'h5);
        #1 chk("R7 irq drops", {31'd0, b_irq}, 32'h0);
        wr(1, CT, 32'h0010_0000);
        #1 chk("R7 te irq", {31'd0, b_irq}, 32'h1);
    endtask

    task automatic t_side_rst;
        b_side_rst = 1;
        rd_chk(0, ST, "R8 peer reset bit", 32'h00F00200);
        b_side_rst = 0;
        rd_chk(1, CT, "R8 control cleared", 32'h0);
        chk("R8 irq low", {31'd0, b_irq}, 32'h0);
        rd_chk(0, ST, "R8 bit drops", 32'h00F00000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_map();
        t_parallel();
        t_overwrite();
        t_doorbell();
        t_irq();
        t_side_rst();
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule